// File: doc/BRIEF.md
# Two-Channel DMA Controller

This block moves data on its own, without the processor handling each word. Each of its two channels holds a source address, a destination address, a transfer count and a mode word, all written over a small configuration write port. A transfer reads one unit from the source and then writes the same unit to the destination. Each channel can move data memory to memory, from an I/O port to memory, or between two I/O ports. An I/O port is addressed by holding its address fixed.

One shared engine drives a single-beat bus master port. It asks for the bus with a request line and starts once the grant arrives. A channel either gives the bus back after every transfer (cycle steal) or keeps it until its whole count is done (burst). A channel starts when software sets its start bit. If external pacing is enabled in its mode word, the channel also waits for its own request pin. When both channels want the bus, either channel 0 always wins or the channel served last loses. Each channel has its own interrupt line. The line reports completion or an error and can be masked.

Top module: `dmac_top`

## Requirements
- R1: After reset, `irq_o`, `bus_req_o` and `bus_valid_o` are all low.
- R2: Each transfer is a read beat at the source address (`bus_we_o`=0) followed by a write beat at the destination address (`bus_we_o`=1). The write beat carries the data returned by the read. Register select 0 is the source address, 1 the destination, 2 the count (bits 15:0), 3 the mode word and 4 the control word.
- R3: A count of N performs exactly N transfers, and a count of 0 performs 65,536. After the last transfer the channel stops and sets its done status.
- R4: Mode bits 1:0 give the size code: 0 for byte, 1 for halfword, 2 for word. After each transfer an address moves on by 1, 2 or 4. Mode bit 2 holds the source address fixed and mode bit 3 holds the destination address fixed.
- R5: With mode bit 4 clear (cycle steal), `bus_req_o` goes low for at least one cycle after every transfer.
- R6: With mode bit 4 set (burst), `bus_req_o` stays high from the first transfer through the last.
- R7: With `rr_mode_i` low and both channels pending, channel 0 is always served first.
- R8: With `rr_mode_i` high and both channels pending, the channel served most recently is served after the other one.
- R9: With mode bit 5 set, a channel starts a transfer only while its `ext_req_i` bit is high.
- R10: An address misaligned for the size, or size code 3, aborts the channel with error status and no bus beat.
- R11: If `bus_err_i` is high on a completed beat, the channel aborts with error status and issues no further beats.
- R12: `irq_o[c]` is high exactly when mode bit 6 of channel c is set and that channel has done or error status. Control bit 1 clears the status. Control bit 0 arms the channel and also clears its status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rr_mode_i | input | 1 | 1 selects round-robin arbitration, 0 selects fixed priority |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | 1 | Channel addressed by the write |
| cfg_sel_i | input | 3 | Register select |
| cfg_wdata_i | input | 32 | Write data |
| ext_req_i | input | 2 | External request, one bit per channel |
| irq_o | output | 2 | Interrupt, one bit per channel |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_valid_o | output | 1 | Beat valid |
| bus_we_o | output | 1 | Beat is a write |
| bus_addr_o | output | 32 | Beat address |
| bus_size_o | output | 2 | Beat size code |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data |
| bus_ready_i | input | 1 | Beat completes this cycle |
| bus_err_i | input | 1 | Beat completes with an error |

## Verification
Some rules are checked by assertions on every cycle. These are the one-step count decrement, a fixed address holding still, the stop on the last transfer, and the abort on a misaligned address. They also cover the bus request dropping after a cycle-steal transfer and holding through a burst, a read beat coming before each write beat, silence after an error beat, and channel 0 winning under fixed priority. Only the bench scenarios can show the end results across whole runs. These are the total number of beats, including the 65,536-transfer count, the final addresses, whether the data matches, the order in which the two channels are served, pacing by the external request pins, and how the interrupt mask and status clearing behave.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int NCH = 2;
  localparam int IW  = $clog2(NCH);

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_X = 2'd3} size_e;
  typedef enum logic [2:0] {RS_SRC = 3'd0, RS_DST = 3'd1, RS_CNT = 3'd2, RS_MODE = 3'd3, RS_CTRL = 3'd4} reg_sel_e;
  typedef enum logic [1:0] {E_IDLE, E_REQ, E_RD, E_WR} eng_st_e;

  typedef struct packed {
    logic  irq_en;
    logic  ext;
    logic  burst;
    logic  dst_fix;
    logic  src_fix;
    size_e size;
  } mode_t;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [2:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ext_req_i,
  input  logic          beat_done_i,
  input  logic          abort_i,
  output logic          req_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [1:0]    size_o,
  output logic          burst_o,
  output logic          last_o,
  output logic          irq_o
);
  localparam int MW = $bits(mode_t);

  logic [AW-1:0] src_q, dst_q, step;
  logic [CW-1:0] cnt_q;
  mode_t         mode_q;
  logic          armed_q, done_q, err_q, bad;

  assign step = AW'(1) << mode_q.size;

  always_comb begin
    unique case (mode_q.size)
      SZ_B:    bad = 1'b0;
      SZ_H:    bad = src_q[0] | dst_q[0];
      SZ_W:    bad = (|src_q[1:0]) | (|dst_q[1:0]);
      default: bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      mode_q  <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (wr_i && !armed_q) begin
        unique case (sel_i)
          RS_SRC:  src_q  <= wdata_i[AW-1:0];
          RS_DST:  dst_q  <= wdata_i[AW-1:0];
          RS_CNT:  cnt_q  <= wdata_i[CW-1:0];
          RS_MODE: mode_q <= mode_t'(wdata_i[MW-1:0]);
          RS_CTRL: begin
            if (wdata_i[1]) begin
              done_q <= 1'b0;
              err_q  <= 1'b0;
            end
            if (wdata_i[0]) begin
              armed_q <= 1'b1;
              done_q  <= 1'b0;
              err_q   <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (armed_q) begin
        if (abort_i || bad) begin
          armed_q <= 1'b0;
          err_q   <= 1'b1;
        end else if (beat_done_i) begin
          if (!mode_q.src_fix) src_q <= src_q + step;
          if (!mode_q.dst_fix) dst_q <= dst_q + step;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) begin
            armed_q <= 1'b0;
            done_q  <= 1'b1;
          end
        end
      end
    end
  end

  assign req_o   = armed_q && !bad && (!mode_q.ext || ext_req_i);
  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign size_o  = mode_q.size;
  assign burst_o = mode_q.burst;
  assign last_o  = (cnt_q == CW'(1));
  assign irq_o   = mode_q.irq_en && (done_q || err_q);

  p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && beat_done_i && !abort_i && !bad |=> cnt_q == CW'($past(cnt_q) - 1'b1));
  p_last_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && beat_done_i && last_o && !abort_i && !bad |=> done_q && !armed_q);
  p_src_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && beat_done_i && mode_q.src_fix |=> src_q == $past(src_q));
  p_misalign_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && bad |=> err_q && !armed_q);
endmodule

// File: rtl/dmac_arb.sv
module dmac_arb
  import dmac_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rr_mode_i,
  input  logic [NCH-1:0] req_i,
  input  logic           take_i,
  output logic           valid_o,
  output logic [IW-1:0]  idx_o
);
  logic last_q;  // channel served most recently
  logic pref_hi;

  assign pref_hi = rr_mode_i && !last_q;
  assign valid_o = |req_i;
  assign idx_o   = pref_hi ? (req_i[1] ? 1'b1 : 1'b0) : (req_i[0] ? 1'b0 : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= 1'b1;
    else if (take_i) last_q <= idx_o;
  end
endmodule

// File: rtl/dmac_eng.sv
module dmac_eng
  import dmac_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    gnt_valid_i,
  input  logic [IW-1:0]           gnt_idx_i,
  output logic                    take_o,
  output logic [IW-1:0]           act_o,
  input  logic [NCH-1:0][AW-1:0]  src_i,
  input  logic [NCH-1:0][AW-1:0]  dst_i,
  input  logic [NCH-1:0][1:0]     size_i,
  input  logic [NCH-1:0]          burst_i,
  input  logic [NCH-1:0]          last_i,
  output logic                    bus_req_o,
  input  logic                    bus_gnt_i,
  output logic                    bus_valid_o,
  output logic                    bus_we_o,
  output logic [AW-1:0]           bus_addr_o,
  output logic [1:0]              bus_size_o,
  output logic [DW-1:0]           bus_wdata_o,
  input  logic [DW-1:0]           bus_rdata_i,
  input  logic                    bus_ready_i,
  input  logic                    bus_err_i,
  output logic [NCH-1:0]          beat_done_o,
  output logic [NCH-1:0]          abort_o
);
  eng_st_e        st_q;
  logic [IW-1:0]  act_q;
  logic [DW-1:0]  data_q;
  logic [NCH-1:0] act_oh;
  logic           fin;

  assign act_oh = NCH'(1) << act_q;
  assign take_o = (st_q == E_IDLE) && gnt_valid_i;
  assign fin    = (st_q == E_WR) && bus_ready_i && !bus_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= E_IDLE;
      act_q  <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        E_IDLE: if (gnt_valid_i) begin
          act_q <= gnt_idx_i;
          st_q  <= E_REQ;
        end
        E_REQ: if (bus_gnt_i) st_q <= E_RD;
        E_RD: if (bus_ready_i) begin
          if (bus_err_i) st_q <= E_IDLE;
          else begin
            data_q <= bus_rdata_i;
            st_q   <= E_WR;
          end
        end
        E_WR: if (bus_ready_i) begin
          if (!bus_err_i && burst_i[act_q] && !last_i[act_q]) st_q <= E_RD;
          else st_q <= E_IDLE;
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign act_o       = act_q;
  assign bus_req_o   = (st_q != E_IDLE);
  assign bus_valid_o = (st_q == E_RD) || (st_q == E_WR);
  assign bus_we_o    = (st_q == E_WR);
  assign bus_addr_o  = (st_q == E_WR) ? dst_i[act_q] : src_i[act_q];
  assign bus_size_o  = size_i[act_q];
  assign bus_wdata_o = data_q;
  assign beat_done_o = fin ? act_oh : '0;
  assign abort_o     = (bus_valid_o && bus_ready_i && bus_err_i) ? act_oh : '0;

  p_steal_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin && !burst_i[act_q] |=> !bus_req_o);
  p_burst_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin && burst_i[act_q] && !last_i[act_q] |=> bus_req_o && bus_valid_o && !bus_we_o);
  p_rd_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_we_o) |-> $past(bus_valid_o && !bus_we_o && bus_ready_i && !bus_err_i));
  p_err_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_ready_i && bus_err_i |=> !bus_valid_o);
endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rr_mode_i,
  input  logic          cfg_we_i,
  input  logic          cfg_ch_i,
  input  logic [2:0]    cfg_sel_i,
  input  logic [DW-1:0] cfg_wdata_i,
  input  logic [1:0]    ext_req_i,
  output logic [1:0]    irq_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          bus_valid_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_size_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ready_i,
  input  logic          bus_err_i
);
  logic [NCH-1:0][AW-1:0] src, dst;
  logic [NCH-1:0][1:0]    size;
  logic [NCH-1:0]         req, burst, last, done, abort;
  logic                   gvalid, take;
  logic [IW-1:0]          gidx, act;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dmac_chan #(.AW(AW), .DW(DW), .CW(CW)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (cfg_we_i && (cfg_ch_i == IW'(c))),
      .sel_i       (cfg_sel_i),
      .wdata_i     (cfg_wdata_i),
      .ext_req_i   (ext_req_i[c]),
      .beat_done_i (done[c]),
      .abort_i     (abort[c]),
      .req_o       (req[c]),
      .src_o       (src[c]),
      .dst_o       (dst[c]),
      .size_o      (size[c]),
      .burst_o     (burst[c]),
      .last_o      (last[c]),
      .irq_o       (irq_o[c])
    );
  end

  dmac_arb u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rr_mode_i (rr_mode_i),
    .req_i     (req),
    .take_i    (take),
    .valid_o   (gvalid),
    .idx_o     (gidx)
  );

  dmac_eng #(.AW(AW), .DW(DW)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gnt_valid_i (gvalid),
    .gnt_idx_i   (gidx),
    .take_o      (take),
    .act_o       (act),
    .src_i       (src),
    .dst_i       (dst),
    .size_i      (size),
    .burst_i     (burst),
    .last_i      (last),
    .bus_req_o   (bus_req_o),
    .bus_gnt_i   (bus_gnt_i),
    .bus_valid_o (bus_valid_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_size_o  (bus_size_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i),
    .bus_ready_i (bus_ready_i),
    .bus_err_i   (bus_err_i),
    .beat_done_o (done),
    .abort_o     (abort)
  );

  p_fixed_prio_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !rr_mode_i && (&req) |=> act == '0);
endmodule

// File: tb/sim_dmac_top.sv
`timescale 1ns/1ps
module sim_dmac_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rr_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_ch = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  ext_req = '0;
  logic [1:0]  irq;
  logic        bus_req, bus_gnt, bus_valid, bus_we, bus_ready, bus_err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic        gnt_en = 1'b1;
  logic        err_en = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  assign bus_gnt   = bus_req & gnt_en;
  assign bus_ready = bus_valid;
  assign bus_err   = bus_valid & err_en;
  assign bus_rdata = pat(bus_addr);

  dmac_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .rr_mode_i(rr_mode),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .ext_req_i(ext_req), .irq_o(irq),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_valid_o(bus_valid), .bus_we_o(bus_we),
    .bus_addr_o(bus_addr), .bus_size_o(bus_size), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .bus_ready_i(bus_ready), .bus_err_i(bus_err)
  );

  int n_chk = 0, n_fail = 0;
  int rd_n, wr_n, err_n, rises, bad_data;
  logic [31:0] last_rd, last_wr;
  logic [15:0] seq;
  logic prev_req = 1'b0, mon_clr = 1'b0;

  always @(negedge clk) begin
    if (mon_clr) begin
      rd_n = 0; wr_n = 0; err_n = 0; rises = 0; bad_data = 0;
      last_rd = '0; last_wr = '0; seq = '0;
    end else begin
      if (bus_req && !prev_req) rises++;
      if (bus_valid && bus_ready) begin
        if (bus_err) err_n++;
        else if (bus_we) begin
          if (wr_n < 16) seq[wr_n] = bus_addr[15];
          if (bus_wdata !== pat(last_rd)) bad_data++;
          last_wr = bus_addr;
          wr_n++;
        end else begin
          last_rd = bus_addr;
          rd_n++;
        end
      end
    end
    prev_req = bus_req;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic cfg(input logic ch, input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] mk_mode(input int sz, input bit sf, input bit df,
                                          input bit bu, input bit ex, input bit ie);
    return {25'd0, ie, ex, bu, df, sf, 2'(sz)};
  endfunction

  task automatic wait_irq(input logic [1:0] mask, input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if ((irq & mask) == mask) break;
    end
  endtask

  task automatic setup(input logic ch, input logic [31:0] s, input logic [31:0] d,
                       input logic [15:0] n, input logic [31:0] m);
    cfg(ch, 3'd0, s);
    cfg(ch, 3'd1, d);
    cfg(ch, 3'd2, {16'd0, n});
    cfg(ch, 3'd3, m);
  endtask

  typedef struct packed {
    logic [1:0]  sz;
    logic        sf;
    logic        df;
    logic        bu;
    logic [15:0] n;
    logic [31:0] s;
    logic [31:0] d;
  } vec_t;

  localparam vec_t VEC [0:4] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 16'd5, 32'h0000_0100, 32'h0000_1000},
    '{2'd1, 1'b0, 1'b0, 1'b1, 16'd4, 32'h0000_0200, 32'h0000_2000},
    '{2'd2, 1'b1, 1'b0, 1'b1, 16'd3, 32'h0000_0300, 32'h0000_3000},
    '{2'd2, 1'b0, 1'b1, 1'b0, 16'd2, 32'h0000_0400, 32'h0000_4000},
    '{2'd1, 1'b1, 1'b1, 1'b0, 16'd1, 32'h0000_0502, 32'h0000_5002}
  };

  bit finished = 1'b0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 bus_valid", bus_valid, 0);
    rst_n = 1'b1;
    clr_mon();

    // table: R2 R3 R4 R5 R6 R12 on channel 0
    foreach (VEC[i]) begin
      automatic vec_t v = VEC[i];
      automatic longint step = 1 << v.sz;
      clr_mon();
      setup(1'b0, v.s, v.d, v.n, mk_mode(v.sz, v.sf, v.df, v.bu, 1'b0, 1'b1));
      cfg(1'b0, 3'd4, 32'h1);
      wait_irq(2'b01, 200);
      repeat (2) @(negedge clk);
      chk("R3 write count", wr_n, v.n);
      chk("R2 read count", rd_n, v.n);
      chk("R2 data mismatches", bad_data, 0);
      chk("R4 last src", last_rd, v.s + (v.sf ? 0 : (v.n - 1) * step));
      chk("R4 last dst", last_wr, v.d + (v.df ? 0 : (v.n - 1) * step));
      if (v.bu) chk("R6 request rises", rises, 1);
      else      chk("R5 request rises", rises, v.n);
      chk("R12 irq done", irq[0], 1);
      cfg(1'b0, 3'd4, 32'h2);
      chk("R12 irq cleared", irq[0], 0);
    end

    // R7 fixed priority
    rr_mode = 1'b0; gnt_en = 1'b0; clr_mon();
    setup(1'b0, 32'h100, 32'h1000, 16'd3, mk_mode(2, 0, 0, 0, 0, 1));
    setup(1'b1, 32'h600, 32'h8000, 16'd3, mk_mode(2, 0, 0, 0, 0, 1));
    cfg(1'b0, 3'd4, 32'h1);
    cfg(1'b1, 3'd4, 32'h1);
    gnt_en = 1'b1;
    wait_irq(2'b11, 200);
    repeat (2) @(negedge clk);
    chk("R7 service order", seq[5:0], 6'b111000);
    cfg(1'b0, 3'd4, 32'h2); cfg(1'b1, 3'd4, 32'h2);

    // R8 round robin
    rr_mode = 1'b1; gnt_en = 1'b0; clr_mon();
    setup(1'b0, 32'h100, 32'h1000, 16'd3, mk_mode(2, 0, 0, 0, 0, 1));
    setup(1'b1, 32'h600, 32'h8000, 16'd3, mk_mode(2, 0, 0, 0, 0, 1));
    cfg(1'b0, 3'd4, 32'h1);
    cfg(1'b1, 3'd4, 32'h1);
    gnt_en = 1'b1;
    wait_irq(2'b11, 200);
    repeat (2) @(negedge clk);
    chk("R8 service order", seq[5:0], 6'b101010);
    cfg(1'b0, 3'd4, 32'h2); cfg(1'b1, 3'd4, 32'h2);
    rr_mode = 1'b0;

    // R9 external pacing
    clr_mon();
    setup(1'b1, 32'h700, 32'h8100, 16'd2, mk_mode(2, 0, 0, 0, 1, 1));
    cfg(1'b1, 3'd4, 32'h1);
    repeat (20) @(negedge clk);
    chk("R9 no beats without ext", wr_n + rd_n, 0);
    ext_req = 2'b10;
    wait_irq(2'b10, 200);
    repeat (2) @(negedge clk);
    chk("R9 beats with ext", wr_n, 2);
    ext_req = 2'b00;
    cfg(1'b1, 3'd4, 32'h2);

    // R10 misaligned word and bad size code
    clr_mon();
    setup(1'b0, 32'h102, 32'h1000, 16'd2, mk_mode(2, 0, 0, 0, 0, 1));
    cfg(1'b0, 3'd4, 32'h1);
    repeat (5) @(negedge clk);
    chk("R10 misalign irq", irq[0], 1);
    chk("R10 misalign beats", rd_n + wr_n + err_n, 0);
    cfg(1'b0, 3'd4, 32'h2);
    setup(1'b0, 32'h100, 32'h1000, 16'd2, mk_mode(3, 0, 0, 0, 0, 1));
    cfg(1'b0, 3'd4, 32'h1);
    repeat (5) @(negedge clk);
    chk("R10 size3 irq", irq[0], 1);
    chk("R10 size3 beats", rd_n + wr_n + err_n, 0);
    cfg(1'b0, 3'd4, 32'h2);

    // R11 bus error
    clr_mon(); err_en = 1'b1;
    setup(1'b0, 32'h100, 32'h1000, 16'd4, mk_mode(2, 0, 0, 0, 0, 1));
    cfg(1'b0, 3'd4, 32'h1);
    repeat (20) @(negedge clk);
    chk("R11 error beats", err_n, 1);
    chk("R11 good beats", rd_n + wr_n, 0);
    chk("R11 irq", irq[0], 1);
    chk("R11 bus released", bus_req, 0);
    err_en = 1'b0;
    cfg(1'b0, 3'd4, 32'h2);

    // R12 mask holds status
    clr_mon();
    setup(1'b0, 32'h100, 32'h1000, 16'd1, mk_mode(2, 0, 0, 0, 0, 0));
    cfg(1'b0, 3'd4, 32'h1);
    repeat (20) @(negedge clk);
    chk("R12 masked run beats", wr_n, 1);
    chk("R12 masked irq", irq[0], 0);
    cfg(1'b0, 3'd3, mk_mode(2, 0, 0, 0, 0, 1));
    chk("R12 unmasked irq", irq[0], 1);
    cfg(1'b0, 3'd4, 32'h2);
    chk("R12 cleared irq", irq[0], 0);

    // R3 count zero means 65536
    clr_mon();
    setup(1'b0, 32'h0, 32'h0010_0000, 16'd0, mk_mode(2, 0, 0, 1, 0, 1));
    cfg(1'b0, 3'd4, 32'h1);
    wait_irq(2'b01, 140000);
    repeat (2) @(negedge clk);
    chk("R3 count0 writes", wr_n, 65536);
    chk("R3 count0 last dst", last_wr, 32'h0013_FFFC);
    chk("R6 count0 rises", rises, 1);
    chk("R2 count0 data", bad_data, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule